// File: doc/BRIEF.md
# Tree-Structured Binary Magnitude Comparator

This block compares two unsigned N-bit operands and reports whether the first is less than, greater than or equal to the second. It has no clock. The result follows the operands combinationally.

The comparison is built as a balanced binary tree of identical 2-bit compare cells. Each leaf cell takes one adjacent bit pair from each operand and produces a (greater, less) flag pair. Each merge cell treats the flag pairs of its two children as two 2-bit numbers. The child covering the more significant bits forms the upper digit. That child decides the result unless both of its flags are clear, and then the other child decides. The path from the operands to the root passes through log2(N) cells, so the logic depth grows with the log of the width rather than with the width.

A small output stage turns the root's flag pair into three outputs. The equal output is formed only at this stage and is not carried through the tree.

Top module: `tree_cmp`

## Requirements
- R1: `gt_o` is 1 exactly when `a_i` is greater than `b_i`, both read as unsigned integers.
- R2: `lt_o` is 1 exactly when `a_i` is less than `b_i`, both read as unsigned integers.
- R3: `eq_o` is 1 exactly when the two operands are identical, which is the case where neither root flag is set.
- R4: For every operand pair, exactly one of `lt_o`, `gt_o`, `eq_o` is 1.
- R5: No compare cell in the tree, including the root, ever raises its greater flag and its less flag together.
- R6: The outcome is set by the most significant bit position where the operands differ. Any differences below that position have no effect on the outputs.
- R7: The parameter N must be a power of two and at least 2, and any other value stops elaboration. The widths 2, 4, 8 and 32 all give correct results.
- R8: The outputs depend only on the present operands. There is no clock and no state, so a new operand pair is reflected at the outputs without waiting for any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | First unsigned operand |
| b_i | input | N | Second unsigned operand |
| lt_o | output | 1 | First operand is smaller |
| gt_o | output | 1 | First operand is larger |
| eq_o | output | 1 | Operands are identical |

## Verification
The hardest case to reach at wide N is a pair of operands that match over almost all of their length and differ only in one low bit. In that case every merge cell on the path must pass the decision up from its less significant child. Uniform random operands at N=32 almost never produce such a pair. The stimulus therefore builds them on purpose: it flips a single chosen bit of a random value, and it also pairs operands whose upper bits agree with a lower part that runs all-ones against all-zeros. The narrow widths are swept over every operand pair, which covers every leaf input combination and every combination at each merge cell.

// File: rtl/tree_cmp_pkg.sv
package tree_cmp_pkg;

    // Flag pair passed from a compare cell up to its parent
    typedef struct packed {
        logic gt;
        logic lt;
    } cmp_flags_t;

endpackage

// File: rtl/cmp2_cell.sv
// Two-bit magnitude compare cell, used at the leaves and at every merge level
module cmp2_cell (
    input  logic [1:0] x_i,
    input  logic [1:0] y_i,
    output logic       gt_o,
    output logic       lt_o
);
    logic hi_same;

    always_comb begin
        hi_same = ~(x_i[1] ^ y_i[1]);
        // The two product terms can never both be 1, so XOR merges them like OR
        gt_o = (x_i[1] & ~y_i[1]) ^ (hi_same & x_i[0] & ~y_i[0]);
        lt_o = (~x_i[1] & y_i[1]) ^ (hi_same & ~x_i[0] & y_i[0]);
    end

    always_comb begin
        assert_cell_exclusive_R5: assert (!(gt_o && lt_o))
            else $error("cell raised both flags");
    end

endmodule

// File: rtl/cmp_out_stage.sv
// Turns the root flag pair into three one-hot outputs
module cmp_out_stage
    import tree_cmp_pkg::*;
(
    input  cmp_flags_t root_i,
    output logic       lt_o,
    output logic       gt_o,
    output logic       eq_o
);
    always_comb begin
        lt_o = root_i.lt;
        gt_o = root_i.gt;
        eq_o = ~(root_i.gt | root_i.lt);
    end

    always_comb begin
        assert_onehot_out_R4: assert ($onehot({lt_o, gt_o, eq_o}))
            else $error("outputs not one-hot");
    end

endmodule

// File: rtl/tree_cmp.sv
module tree_cmp
    import tree_cmp_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    output logic         lt_o,
    output logic         gt_o,
    output logic         eq_o
);
    // Heap numbering: node 1 is the root, node n has children 2n (upper) and 2n+1 (lower)
    localparam int LEAF_BASE = N / 2;

    logic [N-1:1] node_gt;
    logic [N-1:1] node_lt;
    cmp_flags_t   root_flags;

    if (N < 2 || (N & (N - 1)) != 0) begin : g_bad_width
        $error("tree_cmp: N must be a power of two of at least 2 (R7)");
    end

    for (genvar n = 1; n < N; n++) begin : g_node
        if (n >= LEAF_BASE) begin : g_leaf
            localparam int SLICE = N - 1 - n;
            cmp2_cell u_cell (
                .x_i  (a_i[2*SLICE+1 -: 2]),
                .y_i  (b_i[2*SLICE+1 -: 2]),
                .gt_o (node_gt[n]),
                .lt_o (node_lt[n])
            );
        end else begin : g_merge
            cmp2_cell u_cell (
                .x_i  ({node_gt[2*n], node_gt[2*n+1]}),
                .y_i  ({node_lt[2*n], node_lt[2*n+1]}),
                .gt_o (node_gt[n]),
                .lt_o (node_lt[n])
            );
        end
    end

    always_comb begin
        root_flags.gt = node_gt[1];
        root_flags.lt = node_lt[1];
    end

    cmp_out_stage u_out (
        .root_i (root_flags),
        .lt_o   (lt_o),
        .gt_o   (gt_o),
        .eq_o   (eq_o)
    );

    always_comb begin
        assert_gt_match_R1: assert (gt_o == (a_i > b_i))
            else $error("gt disagrees with operands");
        assert_lt_match_R2: assert (lt_o == (a_i < b_i))
            else $error("lt disagrees with operands");
        assert_eq_match_R3: assert (eq_o == (a_i == b_i))
            else $error("eq disagrees with operands");
    end

endmodule

// File: tb/tb_tree_cmp.sv
module tb_tree_cmp;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;

    logic [3:0] lt_v, gt_v, eq_v;   // index 0:N=2 1:N=4 2:N=8 3:N=32

    // R7: one instance per width
    tree_cmp #(.N(2))  dut_n2 (.a_i(op_a[1:0]), .b_i(op_b[1:0]), .lt_o(lt_v[0]), .gt_o(gt_v[0]), .eq_o(eq_v[0]));
    tree_cmp #(.N(4))  dut_n4 (.a_i(op_a[3:0]), .b_i(op_b[3:0]), .lt_o(lt_v[1]), .gt_o(gt_v[1]), .eq_o(eq_v[1]));
    tree_cmp #(.N(8))  dut_n8 (.a_i(op_a[7:0]), .b_i(op_b[7:0]), .lt_o(lt_v[2]), .gt_o(gt_v[2]), .eq_o(eq_v[2]));
    tree_cmp #(.N(32)) dut    (.a_i(op_a),      .b_i(op_b),      .lt_o(lt_v[3]), .gt_o(gt_v[3]), .eq_o(eq_v[3]));

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] b;
        logic [3:0]  lt;
        logic [3:0]  gt;
        logic [3:0]  eq;
    } exp_t;

    exp_t exp_q[$];
    int   n_tests  = 0;
    int   n_failed = 0;
    bit   done     = 1'b0;

    function automatic int width_of(int idx);
        return (idx == 0) ? 2 : (idx == 1) ? 4 : (idx == 2) ? 8 : 32;
    endfunction

    // Driver: new operands at the falling edge, expected results pushed to the queue
    task automatic apply(input logic [31:0] a, input logic [31:0] b);
        exp_t e;
        @(negedge clk);
        op_a = a;
        op_b = b;
        e.a = a;
        e.b = b;
        for (int i = 0; i < 4; i++) begin
            logic [31:0] m;
            m = (width_of(i) == 32) ? 32'hFFFF_FFFF : ((32'd1 << width_of(i)) - 32'd1);
            e.lt[i] = (a & m) <  (b & m);
            e.gt[i] = (a & m) >  (b & m);
            e.eq[i] = (a & m) == (b & m);
        end
        exp_q.push_back(e);
    endtask

    task automatic check_bit(input string tag, input int w, input exp_t e,
                             input logic act, input logic expv);
        n_tests++;
        if (act !== expv) begin
            n_failed++;
            $display("FAIL %s N=%0d a=%h b=%h actual %b expected %b", tag, w, e.a, e.b, act, expv);
        end
    endtask

    // Monitor: outputs are combinational (R8), so they are read at the next rising edge
    always @(posedge clk) begin
        if (!rst && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            for (int i = 0; i < 4; i++) begin
                check_bit("R1 gt", width_of(i), e, gt_v[i], e.gt[i]);
                check_bit("R2 lt", width_of(i), e, lt_v[i], e.lt[i]);
                check_bit("R3 eq", width_of(i), e, eq_v[i], e.eq[i]);
                check_bit("R4 onehot", width_of(i), e,
                          ($countones({lt_v[i], gt_v[i], eq_v[i]}) == 1), 1'b1);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Idle state: zero operands give equal at every width (R3)
        apply(32'h0, 32'h0);
        // R8: values that change on consecutive cycles
        apply(32'hFFFF_FFFF, 32'h0);
        apply(32'h0, 32'hFFFF_FFFF);
        // R6: the top bit decides despite lower bits pointing the other way
        apply(32'h8000_0000, 32'h7FFF_FFFF);
        apply(32'h0000_0080, 32'h0000_007F);
        apply(32'h0000_0007, 32'h0000_0008);
        // Exhaustive sweep of 8-bit pairs, which also covers N=2 and N=4 exhaustively
        for (int i = 0; i < 65536; i++) begin
            logic [23:0] hi;
            hi = 24'($urandom);
            apply({hi, i[15:8]}, {(i[0] ? hi : 24'($urandom)), i[7:0]});
        end
        // R6 at N=32: a single flipped bit at every position
        for (int r = 0; r < 20; r++) begin
            for (int k = 0; k < 32; k++) begin
                logic [31:0] v;
                v = $urandom;
                apply(v, v ^ (32'd1 << k));
            end
        end
        // Matching upper bits, lower part all-ones against all-zeros
        for (int k = 1; k < 32; k++) begin
            logic [31:0] v, m;
            v = $urandom;
            m = (32'd1 << k) - 32'd1;
            apply(v | m, v & ~m);
            apply(v & ~m, v | m);
            apply(v, v);
        end
        for (int r = 0; r < 2000; r++) apply($urandom, $urandom);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_failed);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_failed++;
            $display("FAIL watchdog expired, actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_failed);
            $finish;
        end
    end

endmodule